// File: doc/BRIEF.md
# Electrode subset routing matrix

The block sits between a 256-electrode recording grid (16 rows by 16 columns) and four 64-channel conversion modules. It drives the power enables of those modules and produces one tagged sample stream, with one electrode sample per clock. Each sample carries the 8-bit index of the electrode it came from.

In training mode all four modules are powered. Each frame scans the whole grid in row-major order, so an offline procedure can see every electrode. In inference mode a 64-entry selection table, loaded from outside, names the electrodes to keep. Each frame emits exactly those 64 electrodes in table order, passing them through a row-then-column switch matrix. Only one conversion module stays powered.

A mode change waits for the end of the current frame. One idle cycle follows, in which the new enables are already applied, and then the first frame of the new mode starts, so a frame is never cut short. Software can write the table only while training is the mode in effect. A write that creates a duplicate entry raises a sticky error bit, and the duplicate entries are still routed.

Top module: `esr_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mod_en_o` is 0, `out_valid_o` is 0 and `dup_err_o` is 0. Reset loads table entry k with electrode index k.
- R2: A training frame (mode_i = 0) is 256 consecutive valid samples, with indices 0 to 255 in order, where index = row*16 + col. Each sample equals the input of that electrode, and `mod_en_o` = 4'b1111.
- R3: An inference frame (mode_i = 1) is 64 consecutive valid samples, one per table entry, in entry order 0 to 63. Each entry gives row in bits [7:4] and column in bits [3:0], `out_idx_o` equals the entry, and the sample comes from that electrode. `mod_en_o` = 4'b0001.
- R4: `mode_i` is looked at only in the cycle that emits the last sample of a frame, and in the first cycle after reset. Its value in any other cycle has no effect.
- R5: When the mode seen at a frame end differs from the current one, the next cycle has `out_valid_o` = 0 and already shows the new enables, and the new frame starts in the cycle after that. Frames of the same mode follow back to back with no gap. After reset the first frame starts in the third cycle.
- R6: A write (`wr_en_i`, `wr_addr_i`, `wr_data_i`) made while training is in effect, or before the first frame after reset, updates the entry and shows in later inference frames.
- R7: A write made while inference is in effect is ignored, and later inference frames show the old entry.
- R8: An accepted write whose data equals another entry sets `dup_err_o` from the next cycle until reset, and both entries are still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Requested mode: 0 training, 1 inference |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 6 | Table entry to write |
| wr_data_i | input | 8 | Electrode index: row [7:4], column [3:0] |
| samples_i | input | 2560 | One 10-bit sample per electrode; electrode e at bits [e*10 +: 10] |
| mod_en_o | output | 4 | Power enables of the conversion modules |
| out_valid_o | output | 1 | Output sample valid |
| out_idx_o | output | 8 | Electrode index of the output sample |
| out_sample_o | output | 10 | Output sample |
| dup_err_o | output | 1 | Sticky duplicate-entry flag |

## Verification
The stream is compared each cycle with an independent model, and the electrode samples change every cycle with a per-electrode pattern. This lets a wrong row or column choice, or a one-cycle skew, show up as a sample mismatch. Directed phases cover several cases: inference on the reset table, a full table rewrite with distinct entries, a mode pulse that rises and falls inside a frame and must be ignored, writes made during inference that must be dropped, and a duplicate write that must raise the flag while both copies are still routed. A long random phase mixes mode flips at arbitrary points with random writes, which tests switchover cycles that land on and off frame boundaries.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic {
    MODE_TRAIN = 1'b0,
    MODE_INFER = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_SCAN = 2'd2
  } scan_st_e;
endpackage

// File: rtl/esr_sel_table.sv
module esr_sel_table
  import esr_pkg::*;
#(
  parameter int SEL_N = 64,
  parameter int IDX_W = 8,
  localparam int AW = $clog2(SEL_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [IDX_W-1:0] wr_data_i,
  input  logic             wr_allow_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [IDX_W-1:0] rd_data_o,
  output logic             dup_err_o
);
  logic [SEL_N-1:0][IDX_W-1:0] mem_q;
  logic [SEL_N-1:0]            hit;
  logic                        dup_q;
  logic                        wr_ok;

  assign wr_ok = wr_en_i && wr_allow_i;

  // compare new entry against every other slot
  for (genvar j = 0; j < SEL_N; j++) begin : g_cmp
    assign hit[j] = (mem_q[j] == wr_data_i) && (AW'(j) != wr_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SEL_N; k++) mem_q[k] <= IDX_W'(k);
      dup_q <= 1'b0;
    end else if (wr_ok) begin
      mem_q[wr_addr_i] <= wr_data_i;
      if (|hit) dup_q <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign dup_err_o = dup_q;

  AST_TABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_allow_i) |=> $stable(mem_q)); // R7

  AST_DUP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_err_o |=> dup_err_o); // R8
endmodule

// File: rtl/esr_xbar.sv
module esr_xbar #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int SW   = 10,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic [ROWS*COLS*SW-1:0] samples_i,
  input  logic [RW-1:0]           row_i,
  input  logic [CW-1:0]           col_i,
  output logic [SW-1:0]           data_o
);
  logic [COLS-1:0][SW-1:0] row_bus;

  // stage 1: row select, one lane per column
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [RW+CW-1:0] e_c;
    assign e_c        = {row_i, CW'(c)};
    assign row_bus[c] = samples_i[int'(e_c)*SW +: SW];
  end

  // stage 2: column select
  assign data_o = row_bus[col_i];
endmodule

// File: rtl/esr_scan_ctrl.sv
module esr_scan_ctrl
  import esr_pkg::*;
#(
  parameter int N_ELEC  = 256,
  parameter int SEL_N   = 64,
  parameter int N_MOD   = 4,
  parameter int ACT_MOD = 0,
  localparam int CNT_W = $clog2(N_ELEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  output scan_st_e         st_o,
  output mode_e            cur_mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [N_MOD-1:0] mod_en_o
);
  scan_st_e         st_q;
  mode_e            cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_MOD-1:0] en_q;
  logic [CNT_W-1:0] last;
  logic             at_end;

  function automatic logic [N_MOD-1:0] en_for(mode_e m);
    return (m == MODE_TRAIN) ? {N_MOD{1'b1}} : (N_MOD'(1) << ACT_MOD);
  endfunction

  assign last   = (cur_q == MODE_TRAIN) ? CNT_W'(N_ELEC-1) : CNT_W'(SEL_N-1);
  assign at_end = (st_q == ST_SCAN) && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= MODE_TRAIN;
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_q  <= ST_PREP;
          cur_q <= mode_i;
          en_q  <= en_for(mode_i);
        end
        ST_PREP: begin
          st_q  <= ST_SCAN;
          cnt_q <= '0;
        end
        ST_SCAN: begin
          if (at_end) begin
            cnt_q <= '0;
            if (mode_i != cur_q) begin
              // enables move now, routing one cycle later
              st_q  <= ST_PREP;
              cur_q <= mode_i;
              en_q  <= en_for(mode_i);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign cur_mode_o = cur_q;
  assign cnt_o      = cnt_q;
  assign mod_en_o   = en_q;

  AST_MODE_HOLD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN && !at_end) |=> $stable(cur_q)); // R4

  AST_INFER_ONE_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && cur_q == MODE_INFER) |-> $countones(mod_en_o) == 1); // R3

  AST_TRAIN_ALL_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && cur_q == MODE_TRAIN) |-> (&mod_en_o)); // R2

  AST_EN_LEADS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PREP) |=> $stable(mod_en_o)); // R5
endmodule

// File: rtl/esr_router.sv
module esr_router
  import esr_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 16,
  parameter int SEL_N   = 64,
  parameter int N_MOD   = 4,
  parameter int ACT_MOD = 0,
  parameter int SW      = 10,
  localparam int RW     = $clog2(ROWS),
  localparam int CW     = $clog2(COLS),
  localparam int IDX_W  = RW + CW,
  localparam int N_ELEC = ROWS * COLS,
  localparam int AW     = $clog2(SEL_N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [IDX_W-1:0]     wr_data_i,
  input  logic [N_ELEC*SW-1:0] samples_i,
  output logic [N_MOD-1:0]     mod_en_o,
  output logic                 out_valid_o,
  output logic [IDX_W-1:0]     out_idx_o,
  output logic [SW-1:0]        out_sample_o,
  output logic                 dup_err_o
);
  scan_st_e         st;
  mode_e            cur_mode;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] tab_idx;
  logic [IDX_W-1:0] idx;

  esr_scan_ctrl #(
    .N_ELEC (N_ELEC),
    .SEL_N  (SEL_N),
    .N_MOD  (N_MOD),
    .ACT_MOD(ACT_MOD)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_e'(mode_i)),
    .st_o      (st),
    .cur_mode_o(cur_mode),
    .cnt_o     (cnt),
    .mod_en_o  (mod_en_o)
  );

  esr_sel_table #(
    .SEL_N(SEL_N),
    .IDX_W(IDX_W)
  ) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_allow_i(cur_mode == MODE_TRAIN),
    .rd_addr_i (cnt[AW-1:0]),
    .rd_data_o (tab_idx),
    .dup_err_o (dup_err_o)
  );

  assign idx = (cur_mode == MODE_TRAIN) ? cnt : tab_idx;

  esr_xbar #(
    .ROWS(ROWS),
    .COLS(COLS),
    .SW  (SW)
  ) u_xbar (
    .samples_i(samples_i),
    .row_i    (idx[IDX_W-1 -: RW]),
    .col_i    (idx[CW-1:0]),
    .data_o   (out_sample_o)
  );

  assign out_valid_o = (st == ST_SCAN);
  assign out_idx_o   = idx;

  AST_VALID_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (mod_en_o != '0)); // R5

  AST_NO_VALID_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $changed(mod_en_o)) |-> 1'b0); // R5
endmodule

// File: tb/esr_router_tb.sv
module esr_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;
  localparam int N_ELEC = 256;
  localparam int SEL_N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_r = 1'b1;
  logic wr_en_r = 1'b0;
  logic [5:0] wr_addr_r = '0;
  logic [7:0] wr_data_r = '0;
  int salt = 0;
  logic [N_ELEC*SW-1:0] samples;
  logic [3:0] mod_en;
  logic out_valid;
  logic [7:0] out_idx;
  logic [SW-1:0] out_sample;
  logic dup_err;

  int n_chk = 0;
  int n_bad = 0;
  string ph = "R1";

  // bench model state
  int m_st;   // 0 idle, 1 prep, 2 scan
  int m_cur;  // 0 train, 1 infer
  int m_cnt;
  logic [7:0] m_tab [SEL_N];
  logic m_dup;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW-1:0] smp(int e, int s);
    return SW'(e * 29 + s * 11 + (e >> 3));
  endfunction

  always_comb begin
    for (int e = 0; e < N_ELEC; e++) samples[e*SW +: SW] = smp(e, salt);
  end

  esr_router u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode_r),
    .wr_en_i     (wr_en_r),
    .wr_addr_i   (wr_addr_r),
    .wr_data_i   (wr_data_r),
    .samples_i   (samples),
    .mod_en_o    (mod_en),
    .out_valid_o (out_valid),
    .out_idx_o   (out_idx),
    .out_sample_o(out_sample),
    .dup_err_o   (dup_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s/%s %s: actual %0d expected %0d at %0t", req, ph, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cur = 0; m_cnt = 0; m_dup = 1'b0;
    for (int k = 0; k < SEL_N; k++) m_tab[k] = 8'(k);
  endtask

  task automatic model_step();
    int last;
    if (wr_en_r && m_cur == 0) begin
      for (int j = 0; j < SEL_N; j++)
        if (j != int'(wr_addr_r) && m_tab[j] == wr_data_r) m_dup = 1'b1;
      m_tab[wr_addr_r] = wr_data_r;
    end
    last = (m_cur == 0) ? N_ELEC - 1 : SEL_N - 1;
    case (m_st)
      0: begin m_st = 1; m_cur = int'(mode_r); end
      1: begin m_st = 2; m_cnt = 0; end
      default: begin
        if (m_cnt == last) begin
          m_cnt = 0;
          if (int'(mode_r) != m_cur) begin m_st = 1; m_cur = int'(mode_r); end
        end else m_cnt++;
      end
    endcase
  endtask

  task automatic compare();
    int e_idx;
    int e_en;
    string rq;
    e_en = (m_st == 0) ? 0 : (m_cur == 0 ? 15 : 1);
    rq = (m_cur == 0) ? "R2" : "R3";
    chk("R5", "mod_en", int'(mod_en), e_en);
    chk("R5", "valid", int'(out_valid), (m_st == 2) ? 1 : 0);
    chk("R8", "dup_err", int'(dup_err), int'(m_dup));
    if (m_st == 2) begin
      e_idx = (m_cur == 0) ? m_cnt : int'(m_tab[m_cnt]);
      chk(rq, "idx", int'(out_idx), e_idx);
      chk(rq, "sample", int'(out_sample), int'(smp(e_idx, salt)));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare();
    wr_en_r = 1'b0;
    salt = int'($urandom_range(0, 1023));
  endtask

  task automatic wait_frame_end();
    // returns after the cycle that shows the last sample of a frame
    int last;
    do begin
      tick();
      last = (m_cur == 0) ? N_ELEC - 1 : SEL_N - 1;
    end while (!(m_st == 2 && m_cnt == last));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    // R1: reset state
    #(CLK_PERIOD * 2 + 3);
    chk("R1", "mod_en in reset", int'(mod_en), 0);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "dup in reset", int'(dup_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R5: first cycles after reset, then identity table in inference
    ph = "R1";
    for (int i = 0; i < 3 * 66; i++) tick();

    // R6: switch to training, rewrite full table with distinct entries
    ph = "R6";
    mode_r = 1'b0;
    wait_frame_end();
    tick();
    tick();
    for (int k = 0; k < SEL_N; k++) begin
      wr_en_r = 1'b1; wr_addr_r = 6'(k);
      wr_data_r = 8'(k * 4 + int'($urandom_range(0, 3)));
      tick();
    end
    for (int i = 0; i < 300; i++) tick();
    mode_r = 1'b1;
    for (int i = 0; i < 400; i++) tick();

    // R4: mode pulse inside an inference frame is ignored
    ph = "R4";
    while (!(m_st == 2 && m_cnt == 10)) tick();
    mode_r = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    mode_r = 1'b1;
    for (int i = 0; i < 150; i++) tick();

    // R7: writes during inference are dropped
    ph = "R7";
    for (int i = 0; i < 40; i++) begin
      wr_en_r = 1'b1; wr_addr_r = 6'($urandom_range(0, 63));
      wr_data_r = 8'($urandom_range(0, 255));
      tick();
    end
    for (int i = 0; i < 140; i++) tick();

    // R8: duplicate write in training, then both copies routed
    ph = "R8";
    mode_r = 1'b0;
    wait_frame_end();
    tick();
    wr_en_r = 1'b1; wr_addr_r = 6'd7; wr_data_r = m_tab[20];
    tick();
    chk("R8", "dup set after duplicate write", int'(dup_err), 1);
    mode_r = 1'b1;
    for (int i = 0; i < 600; i++) tick();

    // random mix of mode flips and writes
    ph = "R4";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 99) < 2) mode_r = ~mode_r;
      if ($urandom_range(0, 99) < 5) begin
        wr_en_r = 1'b1; wr_addr_r = 6'($urandom_range(0, 63));
        wr_data_r = 8'($urandom_range(0, 255));
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule